// File: doc/BRIEF.md
# Integer Multiply and Divide Execution Unit

This unit carries out the eight 32-bit integer multiply, divide and remainder operations of a RISC-V core's M extension. The core's decode stage hands it one request at a time. A request holds a 3-bit operation code, the two source operand values, and the three register indices it was decoded with. The unit returns one response. A response is either a result with a register-write enable, or an illegal-instruction report that carries a cause code. The register file, instruction fetch, decode and trap handling all sit outside the unit.

The request side is a valid/ready handshake. `req_ready` is high only while the unit is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. From that edge until the response cycle, `req_ready` stays low and `req_valid` is ignored. The response side has no back-pressure. `rsp_done` is a single-cycle strobe, and the consumer must take `rsp_result`, `rsp_wen`, `rsp_rd`, `rsp_illegal` and `rsp_cause` in that cycle.

The operand width, the register file size (32 for the full base, 16 for the embedded base) and the index width are parameters. Multiplication passes through one registered wide product. Division runs a restoring shift-subtract loop over operand magnitudes, one quotient bit per cycle, and then corrects the signs. A zero divisor and signed overflow give the defined results without trapping and without running the loop.

Top module: `md_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_done`, `rsp_wen` and `rsp_illegal` are 0.
- R2: `req_ready` is low from the accepting edge until the response cycle. `req_valid` is ignored while busy: no extra response follows, and the pending result is unaffected.
- R3: `rsp_done` never stays high for two consecutive cycles, and `rsp_wen` is high only together with `rsp_done`.
- R4: Operation codes 0 to 3 multiply and return the following:
  - code 0: the low word of the signed×signed product;
  - code 1: the high word of the signed×signed product;
  - code 2: the high word with the first operand signed and the second unsigned;
  - code 3: the high word of the unsigned×unsigned product.
- R5: Code 4 (signed quotient) truncates toward zero. Code 6 (signed remainder) gives a remainder that carries the sign of the dividend.
- R6: Code 5 gives the unsigned quotient and code 7 gives the unsigned remainder.
- R7: With a zero divisor, the quotient codes (4, 5) return all ones and the remainder codes (6, 7) return the dividend unchanged.
- R8: Signed division of the most negative value by -1 returns the most negative value (code 4) and 0 (code 6).
- R9: If any of the destination or source indices is at or above `REG_COUNT`, the response has `rsp_illegal`=1, `rsp_cause`=2 and `rsp_wen`=0. This case takes precedence over every arithmetic case.
- R10: With a destination index of 0, the result still appears on `rsp_result`, but `rsp_wen` stays 0.
- R11: Counted in rising edges after the accepting edge, the response appears on the following edge:
  - edge 1 for an illegal request, a zero divisor or signed overflow;
  - edge 2 for a multiply;
  - edge XLEN+2 for any other division.
- R12: `rsp_rd` carries the request's destination index, and `req_ready` is already 1 in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_op | input | 3 | Operation code, see R4 to R6 |
| req_a | input | XLEN | First source operand value |
| req_b | input | XLEN | Second source operand value |
| req_rs1 | input | IDX_W | First source index |
| req_rs2 | input | IDX_W | Second source index |
| req_rd | input | IDX_W | Destination index |
| rsp_done | output | 1 | Response strobe, one cycle |
| rsp_result | output | XLEN | Result value |
| rsp_wen | output | 1 | Register write enable |
| rsp_rd | output | IDX_W | Destination index of the response |
| rsp_illegal | output | 1 | Illegal-instruction request |
| rsp_cause | output | 4 | Exception cause code, 2 when illegal |

## Verification
Three decisions are all made in the same checking cycle:
- the out-of-range index decision;
- the zero-divisor or overflow shortcut;
- the destination-zero write suppression.

The bench provokes the collision by sending zero-divisor and overflow divisions with one index raised to the configured limit or above, and destination-zero requests with all indices legal. It judges each response by its edge count and flags. An illegal request must report cause 2 with no write on edge 1, even when the shortcut would also have finished on edge 1. A destination-zero shortcut must still show the correct value with the write enable low.

// File: rtl/md_pkg.sv
package md_pkg;

  // Operation codes follow the funct3 order the decoder already produces.
  typedef enum logic [2:0] {
    OP_MUL    = 3'd0,
    OP_MULH   = 3'd1,
    OP_MULHSU = 3'd2,
    OP_MULHU  = 3'd3,
    OP_DIV    = 3'd4,
    OP_DIVU   = 3'd5,
    OP_REM    = 3'd6,
    OP_REMU   = 3'd7
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_MUL   = 2'd2,
    ST_DIV   = 2'd3
  } md_state_e;

  localparam int CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 4'd2;

endpackage

// File: rtl/md_idx_check.sv
module md_idx_check #(
  parameter int IDX_W     = 5,
  parameter int REG_COUNT = 32
) (
  input  logic [IDX_W-1:0] idx_rs1,
  input  logic [IDX_W-1:0] idx_rs2,
  input  logic [IDX_W-1:0] idx_rd,
  output logic             out_of_range
);
  localparam int N_IDX = 3;

  logic [IDX_W-1:0] idx_set [N_IDX];
  logic [N_IDX-1:0] over;

  assign idx_set[0] = idx_rs1;
  assign idx_set[1] = idx_rs2;
  assign idx_set[2] = idx_rd;

  for (genvar g = 0; g < N_IDX; g++) begin : g_cmp
    assign over[g] = int'(idx_set[g]) >= REG_COUNT;
  end

  assign out_of_range = |over;
endmodule

// File: rtl/md_multiplier.sv
module md_multiplier #(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              en,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  input  logic              a_signed,
  input  logic              b_signed,
  output logic [2*XLEN-1:0] product
);
  localparam int PW = 2 * XLEN;

  logic [PW-1:0] ext_a;
  logic [PW-1:0] ext_b;

  // Extending both operands to full width makes the truncated product exact
  // for every sign mix.
  assign ext_a = {{XLEN{a_signed & op_a[XLEN-1]}}, op_a};
  assign ext_b = {{XLEN{b_signed & op_b[XLEN-1]}}, op_b};

  always_ff @(posedge clk) begin
    if (en) product <= ext_a * ext_b;
  end
endmodule

// File: rtl/md_divider.sv
module md_divider #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  output logic            fin,
  output logic [XLEN-1:0] quotient,
  output logic [XLEN-1:0] remainder
);
  localparam int CW = $clog2(XLEN + 1);

  logic [XLEN-1:0] rem_q, quo_q, dsr_q;
  logic [CW-1:0]   cnt_q;
  logic [XLEN:0]   shifted, trial;

  assign shifted = {rem_q, quo_q[XLEN-1]};
  assign trial   = shifted - {1'b0, dsr_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= dividend;
        dsr_q <= divisor;
        cnt_q <= CW'(XLEN);
      end else if (cnt_q != '0) begin
        // restoring step: keep the difference only when it is non-negative
        if (!trial[XLEN]) begin
          rem_q <= trial[XLEN-1:0];
          quo_q <= {quo_q[XLEN-2:0], 1'b1};
        end else begin
          rem_q <= shifted[XLEN-1:0];
          quo_q <= {quo_q[XLEN-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) fin <= 1'b1;
      end
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
endmodule

// File: rtl/md_unit.sv
module md_unit
  import md_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_COUNT = 32,
  parameter int IDX_W     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_op,
  input  logic [XLEN-1:0]    req_a,
  input  logic [XLEN-1:0]    req_b,
  input  logic [IDX_W-1:0]   req_rs1,
  input  logic [IDX_W-1:0]   req_rs2,
  input  logic [IDX_W-1:0]   req_rd,
  output logic               rsp_done,
  output logic [XLEN-1:0]    rsp_result,
  output logic               rsp_wen,
  output logic [IDX_W-1:0]   rsp_rd,
  output logic               rsp_illegal,
  output logic [CAUSE_W-1:0] rsp_cause
);
  localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

  md_state_e        state_q;
  md_op_e           op_q;
  logic [XLEN-1:0]  a_q, b_q;
  logic [IDX_W-1:0] rs1_q, rs2_q, rd_q;

  logic accept;
  logic idx_bad;
  logic is_div, div_signed, want_rem;
  logic b_zero, ovf, shortcut;
  logic [XLEN-1:0] shortcut_val;
  logic a_neg, b_neg;
  logic [XLEN-1:0] a_mag, b_mag;
  logic mul_en, div_start, div_fin;
  logic [2*XLEN-1:0] product;
  logic [XLEN-1:0] mul_val, div_quo, div_rem, div_val;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  md_idx_check #(.IDX_W(IDX_W), .REG_COUNT(REG_COUNT)) u_idx (
    .idx_rs1      (rs1_q),
    .idx_rs2      (rs2_q),
    .idx_rd       (rd_q),
    .out_of_range (idx_bad)
  );

  // operation decode
  assign is_div     = op_q[2];
  assign div_signed = ~op_q[0];
  assign want_rem   = op_q[1];

  // division shortcuts
  assign b_zero   = (b_q == '0);
  assign ovf      = is_div && div_signed && (a_q == MOST_NEG) && (b_q == '1);
  assign shortcut = is_div && (b_zero || ovf);

  always_comb begin
    if (b_zero) shortcut_val = want_rem ? a_q : '1;
    else        shortcut_val = want_rem ? '0  : a_q;
  end

  // magnitudes for the divider
  assign a_neg = div_signed && a_q[XLEN-1];
  assign b_neg = div_signed && b_q[XLEN-1];
  assign a_mag = a_neg ? (~a_q + 1'b1) : a_q;
  assign b_mag = b_neg ? (~b_q + 1'b1) : b_q;

  assign mul_en    = (state_q == ST_CHECK) && !idx_bad && !is_div;
  assign div_start = (state_q == ST_CHECK) && !idx_bad && is_div && !shortcut;

  md_multiplier #(.XLEN(XLEN)) u_mul (
    .clk      (clk),
    .en       (mul_en),
    .op_a     (a_q),
    .op_b     (b_q),
    .a_signed (op_q != OP_MULHU),
    .b_signed (~op_q[1]),
    .product  (product)
  );

  md_divider #(.XLEN(XLEN)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (div_start),
    .dividend  (a_mag),
    .divisor   (b_mag),
    .fin       (div_fin),
    .quotient  (div_quo),
    .remainder (div_rem)
  );

  assign mul_val = (op_q == OP_MUL) ? product[XLEN-1:0] : product[2*XLEN-1:XLEN];

  // sign correction: quotient by sign mismatch, remainder follows the dividend
  always_comb begin
    if (want_rem) div_val = a_neg ? (~div_rem + 1'b1) : div_rem;
    else          div_val = (a_neg ^ b_neg) ? (~div_quo + 1'b1) : div_quo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_MUL;
      a_q         <= '0;
      b_q         <= '0;
      rs1_q       <= '0;
      rs2_q       <= '0;
      rd_q        <= '0;
      rsp_done    <= 1'b0;
      rsp_result  <= '0;
      rsp_wen     <= 1'b0;
      rsp_rd      <= '0;
      rsp_illegal <= 1'b0;
      rsp_cause   <= '0;
    end else begin
      rsp_done    <= 1'b0;
      rsp_wen     <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_cause   <= '0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= md_op_e'(req_op);
            a_q     <= req_a;
            b_q     <= req_b;
            rs1_q   <= req_rs1;
            rs2_q   <= req_rs2;
            rd_q    <= req_rd;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (idx_bad) begin
            rsp_done    <= 1'b1;
            rsp_illegal <= 1'b1;
            rsp_cause   <= CAUSE_ILLEGAL;
            rsp_rd      <= rd_q;
            state_q     <= ST_IDLE;
          end else if (!is_div) begin
            state_q <= ST_MUL;
          end else if (shortcut) begin
            rsp_done   <= 1'b1;
            rsp_result <= shortcut_val;
            rsp_wen    <= (rd_q != '0);
            rsp_rd     <= rd_q;
            state_q    <= ST_IDLE;
          end else begin
            state_q <= ST_DIV;
          end
        end
        ST_MUL: begin
          rsp_done   <= 1'b1;
          rsp_result <= mul_val;
          rsp_wen    <= (rd_q != '0);
          rsp_rd     <= rd_q;
          state_q    <= ST_IDLE;
        end
        ST_DIV: begin
          if (div_fin) begin
            rsp_done   <= 1'b1;
            rsp_result <= div_val;
            rsp_wen    <= (rd_q != '0);
            rsp_rd     <= rd_q;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/md_unit_chk.sv
module md_unit_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_done,
  input logic             rsp_wen,
  input logic [IDX_W-1:0] rsp_rd,
  input logic             rsp_illegal,
  input logic [3:0]       rsp_cause
);
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R3
  wen_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wen |-> rsp_done);

  // R9
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> (rsp_done && !rsp_wen && rsp_cause == 4'd2));

  // R10
  rd_zero_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_rd == '0) |-> !rsp_wen);

  // R12
  ready_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);
endmodule

bind md_unit md_unit_chk #(.IDX_W(IDX_W)) u_md_unit_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_done    (rsp_done),
  .rsp_wen     (rsp_wen),
  .rsp_rd      (rsp_rd),
  .rsp_illegal (rsp_illegal),
  .rsp_cause   (rsp_cause)
);

// File: tb/tb_md_unit.sv
module tb_md_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XW = 32;
  localparam int RC = 16;
  localparam int IW = 5;
  localparam logic [31:0] MINV = 32'h8000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [XW-1:0] req_a = '0, req_b = '0;
  logic [IW-1:0] req_rs1 = '0, req_rs2 = '0, req_rd = '0;
  logic          rsp_done, rsp_wen, rsp_illegal;
  logic [XW-1:0] rsp_result;
  logic [IW-1:0] rsp_rd;
  logic [3:0]    rsp_cause;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  md_unit #(.XLEN(XW), .REG_COUNT(RC), .IDX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .req_rs1(req_rs1),
    .req_rs2(req_rs2), .req_rd(req_rd), .rsp_done(rsp_done),
    .rsp_result(rsp_result), .rsp_wen(rsp_wen), .rsp_rd(rsp_rd),
    .rsp_illegal(rsp_illegal), .rsp_cause(rsp_cause)
  );

  task automatic check(input string tg, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tg, what, got, exp);
    end
  endtask

  function automatic logic [31:0] ref_calc(input logic [2:0] op, input logic [31:0] a,
                                           input logic [31:0] b);
    logic [63:0] sa, sb, ua, ub, p;
    int ia, ib;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    ua = {32'b0, a};
    ub = {32'b0, b};
    ia = a;
    ib = b;
    case (op)
      3'd0: begin p = sa * sb; return p[31:0]; end
      3'd1: begin p = sa * sb; return p[63:32]; end
      3'd2: begin p = sa * ub; return p[63:32]; end
      3'd3: begin p = ua * ub; return p[63:32]; end
      3'd4: begin
        if (b == 0) return 32'hFFFF_FFFF;
        if (a == MINV && b == 32'hFFFF_FFFF) return MINV;
        return ia / ib;
      end
      3'd5: return (b == 0) ? 32'hFFFF_FFFF : a / b;
      3'd6: begin
        if (b == 0) return a;
        if (a == MINV && b == 32'hFFFF_FFFF) return 32'd0;
        return ia % ib;
      end
      default: return (b == 0) ? a : a % b;
    endcase
  endfunction

  function automatic bit is_short(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    return op[2] && (b == 0 || (!op[0] && a == MINV && b == 32'hFFFF_FFFF));
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    if (!op[2]) return "R4";
    if (b == 0) return "R7";
    if (is_short(op, a, b)) return "R8";
    return op[0] ? "R6" : "R5";
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [4:0] rs1, input logic [4:0] rs2, input logic [4:0] rd,
                        input bit noise);
    int n;
    bit seen, busy_ok, illegal_exp;
    int exp_lat;
    string tg;
    @(negedge clk);
    check("R2", {31'b0, req_ready}, 32'd1, "ready while idle");
    req_valid = 1'b1; req_op = op; req_a = a; req_b = b;
    req_rs1 = rs1; req_rs2 = rs2; req_rd = rd;
    @(posedge clk);
    @(negedge clk);
    req_valid = noise;
    if (noise) begin req_op = op ^ 3'd5; req_a = ~a; req_b = a; req_rd = 5'd3; end
    n = 0; seen = 0; busy_ok = 1;
    while (!seen && n < 100) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (rsp_done) seen = 1;
      else if (req_ready) busy_ok = 0;
    end
    req_valid = 1'b0;
    illegal_exp = (int'(rs1) >= RC) || (int'(rs2) >= RC) || (int'(rd) >= RC);
    if (illegal_exp) exp_lat = 1;
    else if (!op[2]) exp_lat = 2;
    else if (is_short(op, a, b)) exp_lat = 1;
    else exp_lat = XW + 2;
    check("R2", {31'b0, busy_ok}, 32'd1, "ready low while busy");
    check("R11", n, exp_lat, "response edge");
    check("R12", {31'b0, req_ready}, 32'd1, "ready in response cycle");
    check("R12", {27'b0, rsp_rd}, {27'b0, rd}, "response index");
    if (illegal_exp) begin
      check("R9", {31'b0, rsp_illegal}, 32'd1, "illegal flag");
      check("R9", {28'b0, rsp_cause}, 32'd2, "cause code");
      check("R9", {31'b0, rsp_wen}, 32'd0, "no write when illegal");
    end else begin
      tg = tag_of(op, a, b);
      check(tg, rsp_result, ref_calc(op, a, b), $sformatf("op %0d a %h b %h", op, a, b));
      check("R9", {31'b0, rsp_illegal}, 32'd0, "no illegal flag");
      if (rd == 0) check("R10", {31'b0, rsp_wen}, 32'd0, "write suppressed for index 0");
      else         check("R3", {31'b0, rsp_wen}, 32'd1, "write enable with done");
    end
    @(posedge clk);
    @(negedge clk);
    check("R3", {31'b0, rsp_done}, 32'd0, "strobe lasts one cycle");
    check("R2", {31'b0, req_ready}, 32'd1, "busy request ignored");
  endtask

  logic [31:0] vals [10];

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vals[0] = 32'd0;         vals[1] = 32'd1;         vals[2] = 32'd2;
    vals[3] = 32'd7;         vals[4] = 32'hFFFF_FFFF; vals[5] = 32'hFFFF_FFFE;
    vals[6] = 32'hFFFF_FFF9; vals[7] = MINV;          vals[8] = 32'h7FFF_FFFF;
    vals[9] = 32'd100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", {31'b0, req_ready}, 32'd1, "reset ready");
    check("R1", {31'b0, rsp_done}, 32'd0, "reset done");
    check("R1", {31'b0, rsp_wen}, 32'd0, "reset wen");
    check("R1", {31'b0, rsp_illegal}, 32'd0, "reset illegal");

    // corner-value sweep over all operations, destination cycles through 0
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run_op(3'(op), vals[i], vals[j], 5'd1, 5'd2, 5'((i + j) % RC), (j % 3) == 0);

    // random operands
    for (int op = 0; op < 8; op++)
      for (int k = 0; k < 40; k++)
        run_op(3'(op), $urandom, (k % 5 == 0) ? ($urandom & 32'hFF) : $urandom,
               5'd3, 5'd4, 5'(1 + k % (RC - 1)), k[0]);

    // index boundary sweep colliding with shortcut cases and multiply
    for (int x = RC - 2; x < RC + 3; x++) begin
      run_op(3'd4, 32'd5, 32'd0, 5'(x), 5'd1, 5'd2, 0);
      run_op(3'd6, MINV, 32'hFFFF_FFFF, 5'd1, 5'(x), 5'd2, 0);
      run_op(3'd1, 32'd9, 32'd9, 5'd1, 5'd2, 5'(x), 0);
      run_op(3'd7, 32'd9, 32'd0, 5'd0, 5'd0, 5'(x), 1);
    end
    run_op(3'd5, 32'd9, 32'd0, 5'd31, 5'd31, 5'd31, 0);
    run_op(3'd4, MINV, 32'hFFFF_FFFF, 5'd1, 5'd2, 5'd0, 0);
    run_op(3'd6, 32'd13, 32'd0, 5'd1, 5'd2, 5'd0, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule